// File: doc/BRIEF.md
# Four-Channel Bus-Stealing Transfer Engine

This block moves data between peripheral registers and memory on behalf of a processor that shares the same data bus with it. Each of its four channels is set up once through a small register-write port with an SFR-side address, a memory-side address, a transfer count and a mode. After that, every pulse on the channel's request strobe moves exactly one byte or one 16-bit word. The engine takes the bus for just the two phases of that one move and then hands it back. Because the engine always outranks the processor, `dma_own` tells the processor side to stay off the bus.

A move has a read phase from the source, followed by a write phase to the destination. The bus side uses a valid/ready handshake. The engine raises `bus_valid` with a stable address, direction and data, and holds them until the bus answers with `bus_ready` high in the same cycle. A low `bus_ready` stalls the engine and nothing is lost. Read data on `bus_rdata` is taken in the cycle of the read handshake. In single mode a channel turns itself off at the end of its block. In repeat mode it reloads the count and the memory address and keeps running.

Top module: `dma4_steal`

## Requirements
- R1: While `rst_n` is low and after it is released, `bus_valid`, `dma_own`, `bus_we`, `bus_word`, `bus_addr`, `bus_wdata` and `done` are all zero until a request is served.
- R2: A write with `cfg_we`=1 goes to channel `cfg_ch`. The field is chosen by `cfg_sel`: 0 selects mode, 1 loads both the count and the count reload, 2 loads both the memory address and its reload, 3 sets the SFR address. The mode bits are: bit0 enable, bit1 word size (1 = 16-bit), bit2 repeat, bit3 direction (0 = SFR to memory, 1 = memory to SFR).
- R3: A byte channel writes `bus_rdata[7:0]` zero-extended and drives `bus_word`=0. A word channel writes all 16 bits and drives `bus_word`=1.
- R4: Each move is one read phase (`bus_we`=0) followed by one write phase (`bus_we`=1). Each phase holds its outputs until `bus_ready`. `dma_own` equals `bus_valid`, and after every write handshake the bus is released for at least one cycle.
- R5: With direction 0 the read uses the SFR address and the write uses the memory address. With direction 1 the two are swapped.
- R6: After each move the memory address advances by 1 for bytes and by 2 for words. The SFR address never changes except by a write with `cfg_sel`=3.
- R7: In single mode, the move that finds the count equal to 1 disables the channel. Its `done` bit pulses for one cycle, on the edge after that move's write handshake.
- R8: In repeat mode, the move that finds the count equal to 1 restores the count and the memory address from their reload values, keeps the channel enabled and pulses `done` as in R7.
- R9: When several channels are pending while the bus is idle, the lowest-numbered channel is served first, one move per bus slot.
- R10: A request to a disabled channel is dropped. Further requests to a channel that is already pending merge into the one pending move.
- R11: When the engine is idle, a request strobe sampled on one edge starts the read phase on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel targeted by the write |
| cfg_sel | input | 2 | Field select (R2) |
| cfg_wdata | input | 16 | Write value |
| req | input | 4 | Per-channel transfer request strobes |
| bus_valid | output | 1 | Bus phase valid |
| bus_ready | input | 1 | Bus accepts the current phase |
| bus_we | output | 1 | 1 = write phase, 0 = read phase |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 16 | Write data during a write phase |
| bus_rdata | input | 16 | Read data, taken on the read handshake |
| dma_own | output | 1 | Engine holds the bus; processor must wait |
| done | output | 4 | One-cycle end-of-block pulse per channel |

## Verification
A request strobe is registered on the first edge, and the read phase begins on the second edge. Each phase then lasts until the edge that sees `bus_ready` high. The `done` pulse and the advanced address take effect on the edge right after the write handshake. The bench holds a behavioural model that steps on the same edges, driven by the same sampled inputs. It compares every bus output and `done` at the falling edge, where all registered results have settled. Bus readiness is driven just after the rising edge, both in an always-ready pattern and in a stall pattern. Directed checks cover the two-edge start latency, the order of addresses under contention, the merging of repeated requests, and the repeat-mode reloads.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RD = 2'd1, PH_WR = 2'd2} phase_t;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_MADR = 2'd2;
  localparam logic [1:0] SEL_SADR = 2'd3;

  localparam int MB_EN   = 0;
  localparam int MB_WORD = 1;
  localparam int MB_RPT  = 2;
  localparam int MB_DIR  = 3;
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          req,
  input  logic          step,
  output logic          pend,
  output logic          word,
  output logic          dir,
  output logic [AW-1:0] madr,
  output logic [AW-1:0] saddr,
  output logic          done
);
  logic          en_q, word_q, rpt_q, dir_q, pend_q, done_q;
  logic [CW-1:0] cnt_q, crl_q;
  logic [AW-1:0] madr_q, mrl_q, saddr_q;
  logic          last, ends_off;
  logic [AW-1:0] inc;

  assign last     = (cnt_q == CW'(1));
  assign ends_off = step && last && !rpt_q;
  assign inc      = word_q ? AW'(2) : AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; word_q <= 1'b0; rpt_q <= 1'b0; dir_q <= 1'b0;
      pend_q <= 1'b0; done_q <= 1'b0;
      cnt_q <= '0; crl_q <= '0; madr_q <= '0; mrl_q <= '0; saddr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (step) begin
        pend_q <= 1'b0;
        if (last) begin
          done_q <= 1'b1;
          if (rpt_q) begin
            cnt_q  <= crl_q;
            madr_q <= mrl_q;
          end else begin
            cnt_q  <= '0;
            en_q   <= 1'b0;
            madr_q <= madr_q + inc;
          end
        end else begin
          cnt_q  <= cnt_q - CW'(1);
          madr_q <= madr_q + inc;
        end
      end
      if (req && en_q && !ends_off) pend_q <= 1'b1;
      if (wr_en) begin
        case (wr_sel)
          SEL_MODE: begin
            en_q   <= wr_data[MB_EN];
            word_q <= wr_data[MB_WORD];
            rpt_q  <= wr_data[MB_RPT];
            dir_q  <= wr_data[MB_DIR];
            if (!wr_data[MB_EN]) pend_q <= 1'b0;
          end
          SEL_CNT: begin
            cnt_q <= wr_data[CW-1:0];
            crl_q <= wr_data[CW-1:0];
          end
          SEL_MADR: begin
            madr_q <= wr_data;
            mrl_q  <= wr_data;
          end
          default: saddr_q <= wr_data;
        endcase
      end
    end
  end

  assign pend  = pend_q;
  assign word  = word_q;
  assign dir   = dir_q;
  assign madr  = madr_q;
  assign saddr = saddr_q;
  assign done  = done_q;

  // R6: SFR address moves only by an explicit write
  p_fixed_sfr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_SADR) |=> $stable(saddr_q));
  // R7: end-of-block flag is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  output logic [N-1:0] gnt
);
  logic [N-1:0] lower;

  assign lower[0] = 1'b0;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign lower[i] = lower[i-1] | pend[i-1];
  end
  assign gnt = pend & ~lower;

  // R9: at most one winner, and channel 0 always wins when pending
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((|pend) == (|gnt)));
  p_ch0_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |-> gnt[0]);
endmodule

// File: rtl/dma4_steal.sv
module dma4_steal
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic [NCH-1:0] req,
  output logic           bus_valid,
  input  logic           bus_ready,
  output logic           bus_we,
  output logic           bus_word,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  output logic           dma_own,
  output logic [NCH-1:0] done
);
  localparam logic [DW-1:0] BYTE_MASK = DW'(8'hFF);

  phase_t         phase_q;
  logic [CHW-1:0] cur_q, gidx;
  logic [DW-1:0]  data_q;
  logic [NCH-1:0] pend, gnt, step, word_v, dir_v;
  logic [AW-1:0]  madr_a  [NCH];
  logic [AW-1:0]  saddr_a [NCH];
  logic           word_s, dir_s;
  logic [AW-1:0]  madr_s, saddr_s;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmac_chan #(.AW(AW), .CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_ch == CHW'(g))),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .req     (req[g]),
      .step    (step[g]),
      .pend    (pend[g]),
      .word    (word_v[g]),
      .dir     (dir_v[g]),
      .madr    (madr_a[g]),
      .saddr   (saddr_a[g]),
      .done    (done[g])
    );
  end

  dmac_arb #(.N(NCH)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .gnt   (gnt)
  );

  always_comb begin
    gidx = '0;
    for (int i = NCH - 1; i >= 0; i--) if (gnt[i]) gidx = CHW'(i);
  end

  always_comb begin
    step = '0;
    if (phase_q == PH_WR && bus_ready) step[cur_q] = 1'b1;
  end

  assign word_s  = word_v[cur_q];
  assign dir_s   = dir_v[cur_q];
  assign madr_s  = madr_a[cur_q];
  assign saddr_s = saddr_a[cur_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cur_q   <= '0;
      data_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (|gnt) begin
          cur_q   <= gidx;
          phase_q <= PH_RD;
        end
        PH_RD: if (bus_ready) begin
          data_q  <= word_s ? bus_rdata : (bus_rdata & BYTE_MASK);
          phase_q <= PH_WR;
        end
        PH_WR: if (bus_ready) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_valid = (phase_q != PH_IDLE);
    bus_we    = (phase_q == PH_WR);
    bus_word  = bus_valid && word_s;
    bus_wdata = bus_we ? data_q : '0;
    case (phase_q)
      PH_RD:   bus_addr = dir_s ? madr_s : saddr_s;
      PH_WR:   bus_addr = dir_s ? saddr_s : madr_s;
      default: bus_addr = '0;
    endcase
  end
  assign dma_own = bus_valid;

  // R4: a stalled phase keeps its address and direction
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we));
  // R4: an accepted read is always followed by the write phase
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_we && bus_ready |=> bus_valid && bus_we);
  // R4: bus goes back to the processor after every accepted write
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_we && bus_ready |=> !bus_valid && !dma_own);
  // R7: a block end is signalled only right after a write handshake
  p_done_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |-> $past(bus_valid && bus_we && bus_ready));
endmodule

// File: tb/dma4_steal_test.sv
module dma4_steal_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  req = '0;
  logic        bus_valid, bus_we, bus_word, dma_own;
  logic        bus_ready = 1'b1;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  done;

  int nchecks = 0, nerr = 0;
  bit stall = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] rdfn(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction
  assign bus_rdata = rdfn(bus_addr);

  dma4_steal uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req(req), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_own(dma_own), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic end_sim();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  endtask

  // bus readiness, changed just after the rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    bus_ready = !stall || (cyc % 3 == 0);
  end

  // behavioural reference
  int mph, mcur, mdata;
  int men[4], mword[4], mrpt[4], mdir[4], mcnt[4], mcrl[4];
  int madr[4], mmrl[4], msad[4], mpend[4], mdone[4];
  bit hit;

  function automatic int m_addr();
    if (mph == 1) return mdir[mcur] ? madr[mcur] : msad[mcur];
    if (mph == 2) return mdir[mcur] ? msad[mcur] : madr[mcur];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mcur = 0; mdata = 0;
      for (int i = 0; i < 4; i++) begin
        men[i] = 0; mword[i] = 0; mrpt[i] = 0; mdir[i] = 0; mcnt[i] = 0; mcrl[i] = 0;
        madr[i] = 0; mmrl[i] = 0; msad[i] = 0; mpend[i] = 0; mdone[i] = 0;
      end
    end else begin
      for (int i = 0; i < 4; i++) mdone[i] = 0;
      if (mph == 0) begin
        hit = 0;
        for (int i = 3; i >= 0; i--) if (mpend[i] != 0) begin mcur = i; hit = 1; end
        if (hit) mph = 1;
      end else if (mph == 1) begin
        if (bus_ready) begin
          mdata = int'(rdfn(16'(m_addr())));
          if (mword[mcur] == 0) mdata = mdata & 255;
          mph = 2;
        end
      end else if (bus_ready) begin
        mpend[mcur] = 0;
        if (mcnt[mcur] == 1) begin
          mdone[mcur] = 1;
          if (mrpt[mcur] != 0) begin
            mcnt[mcur] = mcrl[mcur]; madr[mcur] = mmrl[mcur];
          end else begin
            mcnt[mcur] = 0; men[mcur] = 0;
            madr[mcur] = (madr[mcur] + (mword[mcur] != 0 ? 2 : 1)) & 16'hFFFF;
          end
        end else begin
          mcnt[mcur] = (mcnt[mcur] - 1) & 16'hFFFF;
          madr[mcur] = (madr[mcur] + (mword[mcur] != 0 ? 2 : 1)) & 16'hFFFF;
        end
        mph = 0;
      end
      for (int i = 0; i < 4; i++) if (req[i] && men[i] != 0) mpend[i] = 1;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            men[cfg_ch] = cfg_wdata[0]; mword[cfg_ch] = cfg_wdata[1];
            mrpt[cfg_ch] = cfg_wdata[2]; mdir[cfg_ch] = cfg_wdata[3];
            if (!cfg_wdata[0]) mpend[cfg_ch] = 0;
          end
          2'd1: begin mcnt[cfg_ch] = cfg_wdata; mcrl[cfg_ch] = cfg_wdata; end
          2'd2: begin madr[cfg_ch] = cfg_wdata; mmrl[cfg_ch] = cfg_wdata; end
          default: msad[cfg_ch] = cfg_wdata;
        endcase
      end
    end
  end

  // per-cycle comparison and handshake monitor
  int rdq[$], wrq[$];
  int ndone[4];
  int nwr = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(bus_valid == (mph != 0), "R4 bus_valid", bus_valid, mph != 0);
      chk(dma_own == (mph != 0), "R4 dma_own", dma_own, mph != 0);
      chk(bus_we == (mph == 2), "R4 bus_we", bus_we, mph == 2);
      chk(bus_addr == 16'(m_addr()), "R5 bus_addr", bus_addr, m_addr());
      chk(bus_wdata == 16'(mph == 2 ? mdata : 0), "R3 bus_wdata", bus_wdata, mph == 2 ? mdata : 0);
      chk(bus_word == (mph != 0 && mword[mcur] != 0), "R3 bus_word", bus_word,
          mph != 0 && mword[mcur] != 0);
      for (int i = 0; i < 4; i++)
        chk(done[i] == (mdone[i] != 0), "R7 done", done[i], mdone[i]);
      if (bus_valid && bus_ready && !bus_we) rdq.push_back(int'(bus_addr));
      if (bus_valid && bus_ready && bus_we) begin wrq.push_back(int'(bus_addr)); nwr++; end
      for (int i = 0; i < 4; i++) if (done[i]) ndone[i]++;
    end
  end

  task automatic cfg(input int ch, input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    req = m;
    @(negedge clk);
    req = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    nchecks++; nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    end_sim();
  end

  initial begin
    for (int i = 0; i < 4; i++) ndone[i] = 0;
    idle(3);
    // R1: reset state
    chk(bus_valid == 0 && dma_own == 0 && bus_we == 0, "R1 bus idle in reset", bus_valid, 0);
    chk(done == 0 && bus_addr == 0 && bus_wdata == 0 && bus_word == 0, "R1 outputs zero", done, 0);
    rst_n = 1'b1;
    idle(3);
    chk(bus_valid == 0 && dma_own == 0, "R1 idle after reset", bus_valid, 0);

    // channel 1: byte, single, SFR to memory
    cfg(1, 1, 3); cfg(1, 2, 16'h1000); cfg(1, 3, 16'h0040); cfg(1, 0, 4'h1);
    rdq.delete(); wrq.delete();
    // R11: start latency
    @(negedge clk); req = 4'b0010;
    @(negedge clk); req = '0;
    chk(bus_valid == 0, "R11 no phase after first edge", bus_valid, 0);
    @(negedge clk);
    chk(bus_valid == 1 && bus_we == 0, "R11 read phase on second edge", bus_valid, 1);
    idle(6); pulse(4'b0010); idle(6); pulse(4'b0010); idle(8);
    chk(wrq.size() == 3, "R2 three moves after setup", wrq.size(), 3);
    if (wrq.size() == 3) begin
      chk(wrq[0] == 16'h1000 && wrq[1] == 16'h1001 && wrq[2] == 16'h1002,
          "R6 byte step of 1", wrq[2], 16'h1002);
      chk(rdq[0] == 16'h0040 && rdq[2] == 16'h0040, "R5 read from SFR side", rdq[2], 16'h0040);
    end
    chk(ndone[1] == 1, "R7 one done pulse", ndone[1], 1);
    // R10: disabled channel ignores requests
    nwr = 0;
    pulse(4'b0010); idle(10);
    chk(nwr == 0, "R10 disabled request dropped", nwr, 0);

    // channel 2: word, repeat, memory to SFR, stalling bus
    stall = 1;
    cfg(2, 1, 2); cfg(2, 2, 16'h2000); cfg(2, 3, 16'h0080); cfg(2, 0, 4'hF);
    rdq.delete(); wrq.delete();
    for (int k = 0; k < 5; k++) begin pulse(4'b0100); idle(12); end
    chk(rdq.size() == 5, "R8 five moves in repeat", rdq.size(), 5);
    if (rdq.size() == 5)
      chk(rdq[0] == 16'h2000 && rdq[1] == 16'h2002 && rdq[2] == 16'h2000 &&
          rdq[3] == 16'h2002 && rdq[4] == 16'h2000, "R8 address reload", rdq[4], 16'h2000);
    chk(ndone[2] == 2, "R8 done on each block end", ndone[2], 2);
    if (wrq.size() == 5)
      chk(wrq[0] == 16'h0080 && wrq[4] == 16'h0080, "R5 write to SFR side", wrq[4], 16'h0080);
    pulse(4'b0100); idle(12);
    chk(rdq.size() == 6, "R8 channel stays enabled", rdq.size(), 6);

    // contention and merging
    for (int c = 0; c < 4; c++) begin
      cfg(c, 1, 5); cfg(c, 2, 16'h3000 + 16'h100 * c); cfg(c, 3, 16'h0010 + c); cfg(c, 0, 4'h1);
    end
    rdq.delete(); wrq.delete();
    @(negedge clk); req = 4'hF;
    @(negedge clk); req = 4'h8;
    @(negedge clk); req = 4'h8;
    @(negedge clk); req = '0;
    idle(50);
    chk(rdq.size() == 4, "R10 repeated requests merged", rdq.size(), 4);
    if (rdq.size() == 4)
      chk(rdq[0] == 16'h10 && rdq[1] == 16'h11 && rdq[2] == 16'h12 && rdq[3] == 16'h13,
          "R9 lowest channel first", rdq[0], 16'h10);
    stall = 0;
    idle(4);
    end_sim();
  end
endmodule